// File: doc/BRIEF.md
# Multiprocessor UART receive filter

This block is the receive half of a classic microcontroller serial port. It watches an asynchronous serial line and checks it once per tick of a 16x oversampling baud tick. It reassembles frames that are either 8 data bits or 9 data bits long. A receive-done flag tells software that a new byte is waiting in the data register. The ninth data bit, or the stop bit when frames are 8 bits long, is kept in a separate status flag.

A wake-up filter serves multi-drop links. When the multiprocessor enable is set in a 9-bit mode, only frames whose ninth bit is 1 can raise receive-done. Such a frame is an address frame. It must also match a programmable address under a mask, or equal the broadcast value. When the multiprocessor enable is set in the 8-bit mode, a frame raises receive-done only if its stop bit is high.

A bad stop bit always sets a sticky frame error flag. That flag shares one control bit position with the upper mode bit, and a select input chooses which of the two the position reads and writes. While receive-done is still set, a new frame that would be accepted does not replace the data register. Instead it increments an overrun counter.

Top module: `mp_uart_rx`

## Requirements
- R1: In 8-bit mode (mode = {mode_hi, mode_lo} = 01) with mp_en = 0, a frame of one low start bit, 8 data bits sent LSB first and one stop bit loads rx_data with the byte, loads rx_bit8 with the sampled stop bit, and sets rx_done.
- R2: In a 9-bit mode (mode_hi = 1) with mp_en = 0, a frame of one start bit, 9 data bits sent LSB first and one stop bit loads the first eight bits into rx_data, loads the ninth bit into rx_bit8, and sets rx_done.
- R3: In a 9-bit mode with mp_en = 1, a frame whose ninth bit is 0 leaves rx_done clear and leaves rx_data unchanged.
- R4: In a 9-bit mode with mp_en = 1, a frame whose ninth bit is 1 is accepted when (byte & addr_mask) == (addr_given & addr_mask). Otherwise it is dropped, unless R5 applies.
- R5: In a 9-bit mode with mp_en = 1, a frame whose ninth bit is 1 and whose byte equals (addr_given | addr_mask) on all eight bits is accepted even when the masked compare fails.
- R6: In 8-bit mode with mp_en = 1, a frame with a low stop bit is dropped. With mp_en = 0 the same frame is accepted and rx_bit8 reads 0.
- R7: A low sampled stop bit sets frame_err, whether or not the frame is accepted. A later good frame does not clear it. Only a shared write with sel_fe = 1 and shared_wdata = 0 clears it.
- R8: With sel_fe = 0, the shared position reads and writes mode_hi (reset value 0). With sel_fe = 1, it reads and writes frame_err, and writes leave mode_hi unchanged.
- R9: A low pulse on rxd that has ended before mid-bit (sample 8 of 16) is dropped as noise, and no frame is received.
- R10: A frame that would be accepted while rx_done is still set does not change rx_data. It increments overrun_cnt by one.
- R11: While rx_en = 0, or while mode = 00, no frame is received and rx_done stays clear.
- R12: Each bit value is the majority of oversamples 7, 8 and 9. A single inverted sample in the middle of a bit does not change the received bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable |
| mode_lo | input | 1 | Lower mode bit |
| mp_en | input | 1 | Multiprocessor filter enable |
| addr_given | input | 8 | Station address |
| addr_mask | input | 8 | Address mask, 1 = bit is compared |
| sel_fe | input | 1 | Shared position selects frame_err (1) or mode_hi (0) |
| shared_wr | input | 1 | Write strobe for the shared position |
| shared_wdata | input | 1 | Value written to the shared position |
| shared_rd | output | 1 | Read value of the shared position |
| rd_clr | input | 1 | Clears rx_done |
| rx_data | output | 8 | Received byte |
| rx_bit8 | output | 1 | Ninth bit, or stop bit in 8-bit mode |
| rx_done | output | 1 | Receive-done flag |
| frame_err | output | 1 | Sticky frame error flag |
| overrun_cnt | output | 4 | Count of frames lost to a pending byte |

## Verification
Frames with different bit patterns and stop values are sent in the 8-bit mode and in the 9-bit modes. A scoreboard checks each byte and its ninth bit, which tells apart the bit order, the frame length and whether rx_bit8 takes the ninth bit or the stop bit. Address frames that match under the mask, that miss, and that equal only the broadcast value separate the masked compare from the broadcast path, and data frames check that the ninth-bit filter works. A short start pulse, a single inverted mid-bit sample, a frame sent while a byte is pending, and frames sent while reception is disabled check the noise rejection, the majority vote, the overrun handling and the enable gating.

// File: rtl/mp_uart_pkg.sv
package mp_uart_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_START = 2'd1,
      ST_DATA  = 2'd2,
      ST_STOP  = 2'd3
   } rx_state_e;

   localparam int DEF_OVS    = 16;
   localparam int DEF_DW     = 8;
   localparam int DEF_SYNC   = 2;
   localparam int DEF_OVR_W  = 4;
endpackage

// File: rtl/mp_uart_sync.sv
module mp_uart_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   generate
      if (STAGES < 1) begin : g_bad
         $error("mp_uart_sync: STAGES must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[0] <= 1'b1;
               else        pipe_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[i] <= 1'b1;
               else        pipe_q[i] <= pipe_q[i-1];
            end
         end
      end
   endgenerate

   assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/mp_uart_frame.sv
module mp_uart_frame
   import mp_uart_pkg::*;
#(
   parameter int OVS = DEF_OVS,
   parameter int DW  = DEF_DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          nine_bit,
   input  logic          rx,
   output logic          frm_valid,
   output logic [DW:0]   frm_data,
   output logic          frm_stop
);
   localparam int CW  = $clog2(OVS);
   localparam int BW  = $clog2(DW + 1);
   localparam int MID = OVS / 2;
   localparam logic [CW-1:0] C_S0   = CW'(MID - 1);
   localparam logic [CW-1:0] C_S1   = CW'(MID);
   localparam logic [CW-1:0] C_VOTE = CW'(MID + 1);
   localparam logic [CW-1:0] C_LAST = CW'(OVS - 1);
   localparam logic [BW-1:0] B_LAST9 = BW'(DW);
   localparam logic [BW-1:0] B_LAST8 = BW'(DW - 1);

   generate
      if (OVS < 8 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
         $error("mp_uart_frame: OVS must be a power of two, at least 8");
      end
      if (DW < 2) begin : g_bad_dw
         $error("mp_uart_frame: DW must be at least 2");
      end
   endgenerate

   rx_state_e     state_q;
   logic [CW-1:0] cnt_q;
   logic [BW-1:0] bit_q;
   logic [1:0]    smp_q;
   logic          rx_d_q;
   logic          maj;
   logic          vote_pt;
   logic          last_cnt;
   logic [BW-1:0] last_bit;

   always_comb begin
      maj      = (smp_q[1] & smp_q[0]) | (smp_q[1] & rx) | (smp_q[0] & rx);
      vote_pt  = tick && (cnt_q == C_VOTE);
      last_cnt = (cnt_q == C_LAST);
      last_bit = nine_bit ? B_LAST9 : B_LAST8;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cnt_q     <= '0;
         bit_q     <= '0;
         smp_q     <= '0;
         rx_d_q    <= 1'b1;
         frm_valid <= 1'b0;
         frm_data  <= '0;
         frm_stop  <= 1'b1;
      end else begin
         frm_valid <= 1'b0;
         rx_d_q    <= rx;
         if (!en) begin
            state_q <= ST_IDLE;
         end else if (state_q == ST_IDLE) begin
            if (rx_d_q && !rx) begin
               state_q <= ST_START;
               cnt_q   <= '0;
            end
         end else if (tick) begin
            cnt_q <= last_cnt ? '0 : cnt_q + 1'b1;
            if (cnt_q == C_S0 || cnt_q == C_S1) smp_q <= {smp_q[0], rx};
            if (vote_pt) begin
               case (state_q)
                  ST_START: if (maj) state_q <= ST_IDLE;
                  ST_DATA:  frm_data[bit_q] <= maj;
                  ST_STOP: begin
                     frm_valid <= 1'b1;
                     frm_stop  <= maj;
                     state_q   <= ST_IDLE;
                  end
                  default: ;
               endcase
            end
            if (last_cnt) begin
               case (state_q)
                  ST_START: begin
                     state_q  <= ST_DATA;
                     bit_q    <= '0;
                     frm_data <= '0;
                  end
                  ST_DATA: begin
                     if (bit_q == last_bit) state_q <= ST_STOP;
                     else                   bit_q   <= bit_q + 1'b1;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/mp_uart_accept.sv
module mp_uart_accept #(
   parameter int DW         = 8,
   parameter bit ADDR_RECOG = 1'b1
) (
   input  logic          nine_bit,
   input  logic          mp_en,
   input  logic [DW-1:0] byte_in,
   input  logic          bit8,
   input  logic          stop_bit,
   input  logic [DW-1:0] given,
   input  logic [DW-1:0] mask,
   output logic          accept
);
   logic addr_ok;

   generate
      if (ADDR_RECOG) begin : g_recog
         logic hit_mask;
         logic hit_bcast;
         always_comb begin
            hit_mask  = ((byte_in ^ given) & mask) == '0;
            hit_bcast = byte_in == (given | mask);
            addr_ok   = hit_mask | hit_bcast;
         end
      end else begin : g_no_recog
         logic unused_ok;
         always_comb begin
            unused_ok = ^{given, mask, byte_in};
            addr_ok   = 1'b1;
         end
      end
   endgenerate

   always_comb begin
      if (!mp_en)        accept = 1'b1;
      else if (nine_bit) accept = bit8 & addr_ok;
      else               accept = stop_bit;
   end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
   import mp_uart_pkg::*;
#(
   parameter int OVS        = DEF_OVS,
   parameter int DW         = DEF_DW,
   parameter int SYNC       = DEF_SYNC,
   parameter int OVR_W      = DEF_OVR_W,
   parameter bit ADDR_RECOG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             rxd,
   input  logic             rx_en,
   input  logic             mode_lo,
   input  logic             mp_en,
   input  logic [DW-1:0]    addr_given,
   input  logic [DW-1:0]    addr_mask,
   input  logic             sel_fe,
   input  logic             shared_wr,
   input  logic             shared_wdata,
   output logic             shared_rd,
   input  logic             rd_clr,
   output logic [DW-1:0]    rx_data,
   output logic             rx_bit8,
   output logic             rx_done,
   output logic [OVR_W-1:0] overrun_cnt
   ,output logic            frame_err
);
   generate
      if (OVR_W < 1) begin : g_bad_ovr
         $error("mp_uart_rx: OVR_W must be at least 1");
      end
   endgenerate

   logic          rx_s;
   logic          mode_hi_q;
   logic          nine_bit;
   logic          fsm_en;
   logic          frm_valid;
   logic [DW:0]   frm_data;
   logic          frm_stop;
   logic          accept;
   logic          busy;

   assign nine_bit = mode_hi_q;
   assign fsm_en   = rx_en && (mode_hi_q || mode_lo);
   assign busy     = rx_done && !rd_clr;

   mp_uart_sync #(.STAGES(SYNC)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (rx_s)
   );

   mp_uart_frame #(.OVS(OVS), .DW(DW)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .en       (fsm_en),
      .nine_bit (nine_bit),
      .rx       (rx_s),
      .frm_valid(frm_valid),
      .frm_data (frm_data),
      .frm_stop (frm_stop)
   );

   mp_uart_accept #(.DW(DW), .ADDR_RECOG(ADDR_RECOG)) u_accept (
      .nine_bit(nine_bit),
      .mp_en   (mp_en),
      .byte_in (frm_data[DW-1:0]),
      .bit8    (frm_data[DW]),
      .stop_bit(frm_stop),
      .given   (addr_given),
      .mask    (addr_mask),
      .accept  (accept)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         rx_bit8     <= 1'b0;
         rx_done     <= 1'b0;
         overrun_cnt <= '0;
      end else begin
         if (rd_clr) rx_done <= 1'b0;
         if (frm_valid && accept) begin
            if (busy) begin
               overrun_cnt <= overrun_cnt + 1'b1;
            end else begin
               rx_data <= frm_data[DW-1:0];
               rx_bit8 <= nine_bit ? frm_data[DW] : frm_stop;
               rx_done <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_err <= 1'b0;
         mode_hi_q <= 1'b0;
      end else begin
         if (frm_valid && !frm_stop)    frame_err <= 1'b1;
         else if (shared_wr && sel_fe)  frame_err <= shared_wdata;
         if (shared_wr && !sel_fe)      mode_hi_q <= shared_wdata;
      end
   end

   assign shared_rd = sel_fe ? frame_err : mode_hi_q;
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
   parameter int DW    = 8,
   parameter int OVR_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_en,
   input logic             rd_clr,
   input logic             rx_done,
   input logic [DW-1:0]    rx_data,
   input logic             frame_err,
   input logic [OVR_W-1:0] overrun_cnt,
   input logic             shared_wr,
   input logic             shared_wdata,
   input logic             sel_fe,
   input logic             frm_valid,
   input logic             frm_stop
);
   AST_DONE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_done) |-> $past(frm_valid)); // R1

   AST_FE_ON_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !frm_stop) |=> frame_err); // R7

   AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_err && !(shared_wr && sel_fe && !shared_wdata)) |=> frame_err); // R7

   AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && !rd_clr) |=> $stable(rx_data)); // R10

   AST_OVR_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun_cnt != $past(overrun_cnt)) |-> $past(frm_valid && rx_done)); // R10

   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !frm_valid); // R11
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW), .OVR_W(OVR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .rx_en       (rx_en),
   .rd_clr      (rd_clr),
   .rx_done     (rx_done),
   .rx_data     (rx_data),
   .frame_err   (frame_err),
   .overrun_cnt (overrun_cnt),
   .shared_wr   (shared_wr),
   .shared_wdata(shared_wdata),
   .sel_fe      (sel_fe),
   .frm_valid   (frm_valid),
   .frm_stop    (frm_stop)
);

// File: tb/mp_uart_rx_tb_top.sv
`timescale 1ns/1ps
module mp_uart_rx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick;
   logic       rxd = 1'b1;
   logic       rx_en = 1'b1;
   logic       mode_lo = 1'b1;
   logic       mp_en = 1'b0;
   logic [7:0] addr_given = 8'h00;
   logic [7:0] addr_mask = 8'h00;
   logic       sel_fe = 1'b0;
   logic       shared_wr = 1'b0;
   logic       shared_wdata = 1'b0;
   logic       shared_rd;
   logic       rd_clr = 1'b0;
   logic [7:0] rx_data;
   logic       rx_bit8;
   logic       rx_done;
   logic       frame_err;
   logic [3:0] overrun_cnt;

   int checks = 0;
   int errors = 0;
   logic [1:0] tcnt = 2'd0;
   logic [8:0] exp_q[$];
   logic       hold = 1'b0;
   logic       seen = 1'b0;
   logic [7:0] last_data = 8'h00;

   always #2.5 clk = ~clk;

   always @(posedge clk) tcnt <= tcnt + 2'd1;
   assign baud_tick = (tcnt == 2'd0);

   mp_uart_rx dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
      .rx_en(rx_en), .mode_lo(mode_lo), .mp_en(mp_en),
      .addr_given(addr_given), .addr_mask(addr_mask),
      .sel_fe(sel_fe), .shared_wr(shared_wr), .shared_wdata(shared_wdata),
      .shared_rd(shared_rd), .rd_clr(rd_clr), .rx_data(rx_data),
      .rx_bit8(rx_bit8), .rx_done(rx_done), .overrun_cnt(overrun_cnt),
      .frame_err(frame_err)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pops the scoreboard when a byte arrives and clears the flag
   always @(negedge clk) begin
      if (rd_clr) begin
         rd_clr = 1'b0;
      end else if (rst_n && rx_done) begin
         if (!seen) begin
            seen = 1'b1;
            if (exp_q.size() == 0) begin
               chk(1'b0, "unexpected receive-done R3 R6 R9 R11", {23'd0, rx_bit8, rx_data}, 0);
            end else begin
               logic [8:0] e;
               e = exp_q.pop_front();
               chk({rx_bit8, rx_data} == e, "received frame R1 R2 R4 R5 R12",
                   {23'd0, rx_bit8, rx_data}, {23'd0, e});
            end
         end
         if (!hold) begin
            rd_clr = 1'b1;
            seen   = 1'b0;
         end
      end
   end

   task automatic one_tick(input logic v);
      rxd = v;
      do @(negedge clk); while (!baud_tick);
   endtask

   task automatic send_bit(input logic v, input bit glitch);
      for (int t = 0; t < 16; t++) one_tick((glitch && t == 8) ? ~v : v);
   endtask

   // driver: sends one frame and pushes the expected result when accepted
   task automatic send_frame(input int nb, input logic [8:0] d, input logic stp,
                             input int gbit, input bit expect_ok);
      if (expect_ok) begin
         exp_q.push_back({(nb == 9) ? d[8] : stp, d[7:0]});
         last_data = d[7:0];
      end
      send_bit(1'b0, 1'b0);
      for (int b = 0; b < nb; b++) send_bit(d[b], gbit == b);
      send_bit(stp, 1'b0);
      for (int t = 0; t < 24; t++) one_tick(1'b1);
   endtask

   task automatic shared_write(input logic sel, input logic v);
      @(negedge clk);
      sel_fe = sel; shared_wdata = v; shared_wr = 1'b1;
      @(negedge clk);
      shared_wr = 1'b0;
   endtask

   task automatic expect_quiet(input string tag);
      repeat (4) @(negedge clk);
      chk(rx_done == 1'b0, tag, rx_done, 0);
      chk(rx_data == last_data, tag, rx_data, last_data);
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rx_done == 0 && frame_err == 0, "reset flags R7 R1", {rx_done, frame_err}, 0);
      chk(overrun_cnt == 0, "reset overrun R10", overrun_cnt, 0);
      chk(shared_rd == 0, "reset mode_hi R8", shared_rd, 0);
      for (int t = 0; t < 8; t++) one_tick(1'b1);

      // R1: 8-bit frames
      send_frame(8, 9'h0A5, 1'b1, -1, 1'b1);
      send_frame(8, 9'h03C, 1'b1, -1, 1'b1);
      // R12: mid-bit single-sample glitch on bits 2 and 5
      send_frame(8, 9'h00F, 1'b1, 2, 1'b1);
      send_frame(8, 9'h0F0, 1'b1, 5, 1'b1);
      // R9: short start pulse
      for (int t = 0; t < 4; t++) one_tick(1'b0);
      for (int t = 0; t < 40; t++) one_tick(1'b1);
      expect_quiet("start glitch R9");

      // R6: 8-bit with mp_en, bad stop dropped
      mp_en = 1'b1;
      send_frame(8, 9'h0C3, 1'b0, -1, 1'b0);
      expect_quiet("bad stop dropped R6");
      chk(frame_err == 1, "frame error set R7", frame_err, 1);
      mp_en = 1'b0;
      send_frame(8, 9'h081, 1'b0, -1, 1'b1);
      // R7: sticky across a good frame
      send_frame(8, 9'h055, 1'b1, -1, 1'b1);
      chk(frame_err == 1, "frame error sticky R7", frame_err, 1);
      @(negedge clk); sel_fe = 1'b1; #1;
      chk(shared_rd == 1, "shared reads frame error R8", shared_rd, 1);
      shared_write(1'b1, 1'b0);
      chk(frame_err == 0, "frame error cleared R7", frame_err, 0);
      sel_fe = 1'b0; #1;
      chk(shared_rd == 0, "fe write leaves mode_hi R8", shared_rd, 0);

      // R8: enter 9-bit mode through the shared position
      shared_write(1'b0, 1'b1);
      chk(shared_rd == 1, "mode_hi written R8", shared_rd, 1);
      chk(frame_err == 0, "mode write leaves fe R8", frame_err, 0);

      // R2: 9-bit frames
      send_frame(9, 9'h12C, 1'b1, -1, 1'b1);
      send_frame(9, 9'h077, 1'b1, -1, 1'b1);

      // R3/R4/R5 address filter
      mp_en = 1'b1; addr_given = 8'h40; addr_mask = 8'hF0;
      send_frame(9, 9'h041, 1'b1, -1, 1'b0);
      expect_quiet("data frame dropped R3");
      send_frame(9, 9'h14A, 1'b1, -1, 1'b1);
      send_frame(9, 9'h152, 1'b1, -1, 1'b0);
      expect_quiet("address miss dropped R4");
      send_frame(9, 9'h1F0, 1'b1, -1, 1'b1);
      expect_quiet("broadcast accepted R5");

      // R10: overrun
      mp_en = 1'b0; hold = 1'b1;
      send_frame(9, 9'h011, 1'b1, -1, 1'b1);
      send_frame(9, 9'h122, 1'b1, -1, 1'b0);
      chk(rx_data == 8'h11, "no overwrite R10", rx_data, 8'h11);
      chk(overrun_cnt == 1, "overrun counted R10", overrun_cnt, 1);
      hold = 1'b0;
      expect_quiet("cleared after overrun R10");

      // R11: disabled reception
      rx_en = 1'b0;
      send_frame(9, 9'h199, 1'b1, -1, 1'b0);
      expect_quiet("rx_en low R11");
      rx_en = 1'b1; mode_lo = 1'b0;
      shared_write(1'b0, 1'b0);
      send_frame(8, 9'h066, 1'b1, -1, 1'b0);
      expect_quiet("mode 00 R11");

      chk(exp_q.size() == 0, "scoreboard drained R1 R2", exp_q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule